// File: doc/BRIEF.md
# Two-Stage Compare Watchdog

This peripheral guards a system by comparing an externally supplied 64-bit system count against a stored deadline. Software arms it by setting an enable bit and choosing a period, then keeps it quiet by refreshing it. Each refresh moves the deadline to the current count plus the period. If software stops refreshing and the count passes the deadline, the block raises a warning level. It then moves the deadline one more period ahead. If the count passes that second deadline before any refresh, the block raises a reset request. The total silence needed to reach reset is therefore two periods.

Two register windows share one simple single-cycle read/write bus. A one-bit window select picks between them. The refresh window holds only the refresh register and the identification word. The control window holds the control/status word, the period, the read-only deadline and the identification word. The period register is 32 bits wide in revision 0 and 48 bits wide in revision 1. The reset-request status bit is cleared only by a separate power-on reset, so boot software can still read it after the system reset that it caused.

Top module: `wdog2_top`

## Requirements
- R1: After power-on and system reset, the status word (control window, offset 0x000) reads 0, both outputs are low and the deadline reads 0.
- R2: Any write to offset 0x000 of the refresh window, whatever its data, loads the deadline with count plus period and clears the warning status, without changing the period.
- R3: The period register spans control offsets 0x008 (bits 31:0) and 0x00C (bits 47:32 from write bits 15:0, revision 1); upper read bits above the period width are zero; a period write also refreshes using the newly written period.
- R4: With enable set and warning clear, a count strictly greater than the deadline sets the warning status (status bit 1), drives warn_irq high and reloads the deadline with count plus period.
- R5: With enable and warning set, a count strictly greater than the deadline sets the reset status (status bit 2) and drives reset_req high.
- R6: A count equal to the deadline causes no expiry.
- R7: Writing 0 to the status word clears enable (bit 0); while enable is clear no expiry is evaluated and both outputs stay low.
- R8: The reset status survives the system reset (rst_n) and is cleared only by por_n; the system reset clears enable and warning.
- R9: The identification word at offset 0xFCC of both windows reports the revision in bits 19:16 and zero elsewhere.
- R10: Reads of unmapped offsets in either window return zero.
- R11: Any write to the status word refreshes: the warning status clears and the deadline becomes count plus period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset, also clears the reset status |
| sys_cnt | input | 64 | Free-running system count |
| req_valid | input | 1 | Bus access strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_frame | input | 1 | Window select: 0 control, 1 refresh |
| req_addr | input | 12 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle of the read strobe |
| warn_irq | output | 1 | Level warning interrupt after the first expiry |
| reset_req | output | 1 | Reset request after the second expiry |

## Verification
The bench builds the block with revision 1, so the period is 48 bits wide. This makes the upper period half at 0x00C reachable, and it carries the period's upper bits into the upper word of the deadline. The bench drives the system count directly rather than letting it run free. Each deadline can then be placed exactly at equality and one count past it, and both expiry stages are reached within a few cycles.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 64;

  localparam logic [ADDR_W-1:0] OFF_CS     = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_PER_LO = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_PER_HI = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_DL_LO  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_DL_HI  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_REFR   = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_IDENT  = 12'hFCC;

  function automatic int period_width(int rev);
    return (rev == 0) ? 32 : 48;
  endfunction
endpackage

// File: rtl/wdog2_regs.sv
module wdog2_regs
  import wdog2_pkg::*;
#(
  parameter int REV   = 1,
  parameter int PER_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_frame,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  dl,
  input  logic              ws0,
  input  logic              ws1,
  output logic              en,
  output logic [PER_W-1:0]  per_nxt,
  output logic              refresh,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HI_W = PER_W - 32;

  logic wr_c, wr_cs, wr_lo, wr_hi, wr_refr, rd_en;
  logic en_q, en_d;
  logic [31:0] lo_q, lo_d;
  logic [DATA_W-1:0] hi_rd;
  logic [DATA_W-1:0] ident;

  assign wr_c    = req_valid & req_write & ~req_frame;
  assign wr_cs   = wr_c & (req_addr == OFF_CS);
  assign wr_lo   = wr_c & (req_addr == OFF_PER_LO);
  assign wr_hi   = wr_c & (req_addr == OFF_PER_HI) & (HI_W > 0);
  assign wr_refr = req_valid & req_write & req_frame & (req_addr == OFF_REFR);
  assign rd_en   = req_valid & ~req_write;
  assign refresh = wr_cs | wr_lo | wr_hi | wr_refr;
  assign ident   = DATA_W'(REV & 15) << 16;

  always_comb begin
    en_d = en_q;
    if (wr_cs) en_d = req_wdata[0];
    lo_d = lo_q;
    if (wr_lo) lo_d = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      lo_q <= '0;
    end else begin
      if (wr_cs) en_q <= en_d;
      if (wr_lo) lo_q <= lo_d;
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] hi_q, hi_d;
      always_comb begin
        hi_d = hi_q;
        if (wr_hi) hi_d = req_wdata[HI_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_hi) hi_q <= hi_d;
      end
      assign per_nxt = {hi_d, lo_d};
      assign hi_rd   = DATA_W'(hi_q);
    end else begin : g_nohi
      assign per_nxt = lo_d;
      assign hi_rd   = '0;
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (req_frame) begin
        if (req_addr == OFF_IDENT) rd_data = ident;
      end else begin
        case (req_addr)
          OFF_CS:     rd_data = {29'd0, ws1, ws0, en_q};
          OFF_PER_LO: rd_data = lo_q;
          OFF_PER_HI: rd_data = hi_rd;
          OFF_DL_LO:  rd_data = dl[31:0];
          OFF_DL_HI:  rd_data = dl[63:32];
          OFF_IDENT:  rd_data = ident;
          default:    rd_data = '0;
        endcase
      end
    end
  end

  assign en = en_q;
endmodule

// File: rtl/wdog2_expiry.sv
module wdog2_expiry
  import wdog2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             en,
  input  logic             refresh,
  input  logic [CNT_W-1:0] per_ext,
  input  logic [CNT_W-1:0] sys_cnt,
  output logic [CNT_W-1:0] dl,
  output logic             ws0,
  output logic             ws1
);
  logic [CNT_W-1:0] dl_q, dl_d;
  logic ws0_q, ws0_d, ws1_q, ws1_d;
  logic passed;

  assign passed = sys_cnt > dl_q;

  always_comb begin
    dl_d  = dl_q;
    ws0_d = ws0_q;
    ws1_d = ws1_q;
    if (refresh) begin
      dl_d  = sys_cnt + per_ext;
      ws0_d = 1'b0;
    end else if (en && passed) begin
      if (!ws0_q) begin
        ws0_d = 1'b1;
        dl_d  = sys_cnt + per_ext;
      end else begin
        ws1_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q  <= '0;
      ws0_q <= 1'b0;
    end else begin
      dl_q  <= dl_d;
      ws0_q <= ws0_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ws1_q <= 1'b0;
    else        ws1_q <= ws1_d;
  end

  assign dl  = dl_q;
  assign ws0 = ws0_q;
  assign ws1 = ws1_q;
endmodule

// File: rtl/wdog2_top.sv
module wdog2_top
  import wdog2_pkg::*;
#(
  parameter int REV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [63:0]       sys_cnt,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_frame,
  input  logic [11:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              warn_irq,
  output logic              reset_req
);
  localparam int PER_W = period_width(REV);

  logic             en_q;
  logic             refresh;
  logic [PER_W-1:0] per_nxt;
  logic [CNT_W-1:0] per_ext;
  logic [CNT_W-1:0] dl;
  logic             ws0, ws1;

  assign per_ext = CNT_W'(per_nxt);

  wdog2_regs #(.REV(REV), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_frame(req_frame),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .dl(dl), .ws0(ws0), .ws1(ws1),
    .en(en_q), .per_nxt(per_nxt), .refresh(refresh), .rd_data(rd_data)
  );

  wdog2_expiry u_exp (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .en(en_q), .refresh(refresh), .per_ext(per_ext), .sys_cnt(sys_cnt),
    .dl(dl), .ws0(ws0), .ws1(ws1)
  );

  assign warn_irq  = ws0 & en_q;
  assign reset_req = ws1 & en_q;
endmodule

// File: rtl/wdog2_chk.sv
module wdog2_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        por_n,
  input logic        en,
  input logic        refresh,
  input logic        ws0,
  input logic        ws1,
  input logic [63:0] sys_cnt,
  input logic [63:0] dl,
  input logic [63:0] per_ext
);
  // R2 / R11: any refresh leaves the warning clear next cycle
  a_r2_refresh_clears_warn: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !ws0);

  // R4: first expiry reloads the deadline from count plus period
  a_r4_reload_on_warn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws0) |-> (dl == $past(sys_cnt) + $past(per_ext)));

  // R5: reset status only rises while warning is already set
  a_r5_reset_after_warn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws1) |-> $past(ws0));

  // R6: no change of stage before the count passes the deadline
  a_r6_no_early_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    ((sys_cnt <= dl) && !refresh) |=> ($stable(ws0) && $stable(ws1)));

  // R7: no expiry evaluated while disabled
  a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ws0) |=> !ws0);

  // R8: reset status is held until power-on reset
  a_r8_ws1_sticky: assert property (@(posedge clk) disable iff (!por_n)
    ws1 |=> ws1);
endmodule

bind wdog2_top wdog2_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .en(en_q), .refresh(refresh),
  .ws0(ws0), .ws1(ws1), .sys_cnt(sys_cnt), .dl(dl), .per_ext(per_ext)
);

// File: tb/tb_wdog2_top.sv
`timescale 1ns/1ps
module tb_wdog2_top;
  logic        clk;
  logic        rst_n, por_n;
  logic [63:0] sys_cnt;
  logic        req_valid, req_write, req_frame;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic        warn_irq, reset_req;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  wdog2_top #(.REV(1)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .sys_cnt(sys_cnt),
    .req_valid(req_valid), .req_write(req_write), .req_frame(req_frame),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .warn_irq(warn_irq), .reset_req(reset_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic frame, input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_frame = frame;
    req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic frame, input logic [11:0] addr, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_frame = frame; req_addr = addr;
    #1 data = rd_data;
    req_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 12'h000, v); chk("R1 status", v, 0);
    rd(0, 12'h010, v); chk("R1 deadline", v, 0);
    chk("R1 warn", warn_irq, 0);
    chk("R1 reset_req", reset_req, 0);
  endtask

  task automatic t_ident();
    logic [31:0] v;
    rd(0, 12'hFCC, v); chk("R9 ident control", v, 32'h0001_0000);
    rd(1, 12'hFCC, v); chk("R9 ident refresh", v, 32'h0001_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(0, 12'h004, v); chk("R10 ctrl 0x004", v, 0);
    rd(0, 12'h020, v); chk("R10 ctrl 0x020", v, 0);
    rd(1, 12'h008, v); chk("R10 refr 0x008", v, 0);
    rd(1, 12'h000, v); chk("R10 refr 0x000", v, 0);
  endtask

  task automatic t_period();
    logic [31:0] v;
    sys_cnt = 64'd0;
    wr(0, 12'h00C, 32'hABCD_1234);
    wr(0, 12'h008, 32'd100);
    rd(0, 12'h00C, v); chk("R3 period high masked", v, 32'h0000_1234);
    rd(0, 12'h008, v); chk("R3 period low", v, 32'd100);
    rd(0, 12'h014, v); chk("R3 deadline high", v, 32'h0000_1234);
    rd(0, 12'h010, v); chk("R3 deadline low", v, 32'd100);
    wr(0, 12'h00C, 32'h0);
    rd(0, 12'h014, v); chk("R3 hi write refresh", v, 0);
  endtask

  task automatic t_refresh_frame();
    logic [31:0] v;
    sys_cnt = 64'd500;
    wr(1, 12'h000, 32'hDEAD_BEEF);
    rd(0, 12'h010, v); chk("R2 deadline", v, 32'd600);
    rd(0, 12'h008, v); chk("R2 period kept", v, 32'd100);
  endtask

  task automatic t_expiry();
    logic [31:0] v;
    sys_cnt = 64'd1000;
    wr(0, 12'h000, 32'h1);
    rd(0, 12'h010, v); chk("R11 enable refresh", v, 32'd1100);
    sys_cnt = 64'd1100; tick();
    chk("R6 equal no warn", warn_irq, 0);
    sys_cnt = 64'd1101; tick();
    chk("R4 warn_irq", warn_irq, 1);
    rd(0, 12'h010, v); chk("R4 reload", v, 32'd1201);
    rd(0, 12'h000, v); chk("R4 status", v, 32'd3);
    sys_cnt = 64'd1201; tick();
    chk("R6 equal no reset", reset_req, 0);
    sys_cnt = 64'd1202; tick();
    chk("R5 reset_req", reset_req, 1);
    rd(0, 12'h000, v); chk("R5 status", v, 32'd7);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    @(negedge clk); rst_n = 1'b0;
    tick(); tick(); rst_n = 1'b1;
    rd(0, 12'h000, v); chk("R8 ws1 survives", v, 32'd4);
    chk("R8 reset_req off", reset_req, 0);
    chk("R8 warn off", warn_irq, 0);
    @(negedge clk); por_n = 1'b0;
    tick(); por_n = 1'b1;
    rd(0, 12'h000, v); chk("R8 por clears", v, 0);
  endtask

  task automatic t_ctrl_refresh();
    logic [31:0] v;
    sys_cnt = 64'd2000;
    wr(0, 12'h008, 32'd50);
    wr(0, 12'h000, 32'h1);
    sys_cnt = 64'd2051; tick();
    chk("R11 warn set first", warn_irq, 1);
    sys_cnt = 64'd2060;
    wr(0, 12'h000, 32'h1);
    rd(0, 12'h000, v); chk("R11 warn cleared", v, 32'd1);
    rd(0, 12'h010, v); chk("R11 deadline", v, 32'd2110);
    sys_cnt = 64'd2111; tick();
    rd(0, 12'h000, v); chk("R4 second warn", v, 32'd3);
    wr(1, 12'h000, 32'h0);
    rd(0, 12'h000, v); chk("R2 refresh clears warn", v, 32'd1);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    sys_cnt = 64'd2200;
    wr(0, 12'h000, 32'h0);
    rd(0, 12'h000, v); chk("R7 disabled", v, 0);
    sys_cnt = 64'd9000;
    repeat (5) tick();
    chk("R7 warn low", warn_irq, 0);
    chk("R7 reset low", reset_req, 0);
    rd(0, 12'h000, v); chk("R7 no expiry", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; por_n = 1'b0; sys_cnt = '0;
    req_valid = 1'b0; req_write = 1'b0; req_frame = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    t_reset();
    t_ident();
    t_unmapped();
    t_period();
    t_refresh_frame();
    t_expiry();
    t_sticky();
    t_ctrl_refresh();
    t_disable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule